// File: doc/BRIEF.md
# Triangular Spread-Spectrum Divider Modulator

This block sits in front of the fractional-N divider of a clock synthesizer. Once per cycle of the phase-frequency-detector (PFD) clock, it turns a fixed-point nominal divider word into a modulated divider word. The synthesized frequency then sweeps in a triangle around the nominal value or below it, and the modulation rate is close to 31.5 kHz. The spread lowers the peak energy of the clock harmonics. The analog loop, the noise shaper that follows, and the register access all sit outside this block.

Three inputs set the modulation: an enable bit, a mode bit (0 sweeps only downwards, 1 sweeps evenly above and below nominal) and a 3-bit depth code. Bit 1 of the code gives the assumed PFD rate, which sets the ramp length. Bit 0 gives the spread depth. Codes with bit 2 set are reserved. The block holds its settings until the ramp returns to zero offset at a period boundary, so a new setting never makes the divider word jump.

The output offset is `trunc(N * p / (D * H))`. Here N is the nominal word, p is a signed ramp position that moves by one unit per PFD cycle, H is the half-period in cycles and D is the depth denominator. Division truncates toward zero.

Top module: `ssc_modulator`

## Requirements
- R1: While modulation is active, the ramp position p changes by exactly +1 or -1 on every clock cycle, so the divider offset follows straight rising and falling slopes.
- R2: While the applied enable bit is 0, `modDiv` equals `nomDiv` and `modActive` is 0, whatever the mode and code are.
- R3: With centerMode=0 (down spread), starting at a period boundary t=0, the position is p=-t for t<=H and p=t-2H for H<t<2H. `modDiv = nomDiv + trunc(nomDiv*p/(D*H))`, which is never above `nomDiv`.
- R4: With centerMode=1 (center spread), p=t for t<=H/2, p=H-t for t<=3H/2, and p=t-2H up to 2H. `modDiv` uses the same formula as R3.
- R5: Depth code bit 1 selects H=396 (code 0 or 1, 25 MHz PFD) or H=794 (code 2 or 3, 50 MHz PFD). The period is therefore 792 or 1588 cycles. Code bit 0 selects D=400 (0.25 %) or D=200 (0.5 %).
- R6: At the ramp peak, the offset is exactly `trunc(-nomDiv/D)` for down spread. For center spread it is `trunc(+-nomDiv*(H/2)/(D*H))`, which is half the depth on each side.
- R7: A depth code with bit 2 set is applied as no modulation. If it is applied while the enable bit is 1, `codeError` is set and stays set until reset.
- R8: While modulation is active, new enable, mode or code values take effect only on the clock edge that ends a full period, where the ramp is back at zero. When no modulation is applied, new values take effect on the next edge.
- R9: Synchronous reset clears the ramp, the applied settings and `codeError`, so `modDiv` equals `nomDiv` and `modActive` is 0.
- R10: `modActive` is 1 exactly while an enabled, non-reserved setting is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PFD-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| sscEnable | input | 1 | Request modulation |
| centerMode | input | 1 | 0 = down spread, 1 = center spread |
| depthCode | input | 3 | Bit 1: PFD rate / ramp length; bit 0: depth; bit 2: reserved |
| nomDiv | input | DIV_W | Nominal fixed-point divider word |
| modDiv | output | DIV_W | Modulated divider word |
| modActive | output | 1 | Modulation currently applied |
| codeError | output | 1 | Sticky flag: a reserved code was applied while enabled |

## Verification
`modDiv` is computed combinationally from the ramp register. A corrupted ramp position therefore shows up at the output in the same cycle it appears, as an offset that breaks the formula in R3 or R4. A wrong phase counter or direction changes nothing until the next peak or boundary. There the sweep turns in the wrong cycle, so the fault is visible within half a period at most. A mistake in when settings are applied shows up as a new slope beginning before the zero-offset cycle. Checking every cycle over whole periods, for each code and mode, catches all of these.

// File: rtl/ssc_pkg.sv
package ssc_pkg;

  // Strobes from the control FSM to the ramp datapath
  typedef struct packed {
    logic       stepEn;    // advance the ramp this cycle
    logic       stepUp;    // direction of the step
    logic       holdZero;  // force the ramp to zero offset
    logic [1:0] depthSel;  // selects ramp length and depth
  } rampCtl_t;

endpackage

// File: rtl/ssc_ctrl.sv
module ssc_ctrl
  import ssc_pkg::*;
#(
  parameter int HALF_SLOW = 396,
  parameter int HALF_FAST = 794
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       enReq,
  input  logic       centerReq,
  input  logic [2:0] codeReq,
  output rampCtl_t   ctl,
  output logic       centerQ,
  output logic [2:0] codeQ,
  output logic       activeQ,
  output logic       errQ
);

  localparam int PH_W       = $clog2(2 * HALF_FAST);
  localparam int LAST_SLOW  = 2 * HALF_SLOW - 1;
  localparam int LAST_FAST  = 2 * HALF_FAST - 1;
  localparam int Q1_SLOW    = HALF_SLOW / 2;
  localparam int Q1_FAST    = HALF_FAST / 2;
  localparam int Q3_SLOW    = HALF_SLOW + HALF_SLOW / 2;
  localparam int Q3_FAST    = HALF_FAST + HALF_FAST / 2;

  logic            enQ;
  logic [PH_W-1:0] phase;
  logic [PH_W-1:0] lastPh, halfPh, q1Ph, q3Ph;
  logic            running, loadCfg, upDir;

  assign running = enQ && !codeQ[2];

  always_comb begin
    if (codeQ[1]) begin
      lastPh = PH_W'(LAST_FAST);
      halfPh = PH_W'(HALF_FAST);
      q1Ph   = PH_W'(Q1_FAST);
      q3Ph   = PH_W'(Q3_FAST);
    end else begin
      lastPh = PH_W'(LAST_SLOW);
      halfPh = PH_W'(HALF_SLOW);
      q1Ph   = PH_W'(Q1_SLOW);
      q3Ph   = PH_W'(Q3_SLOW);
    end
  end

  // Settings are taken when idle or on the final step of a period
  assign loadCfg = !running || (phase == lastPh);

  always_comb begin
    if (centerQ) upDir = (phase < q1Ph) || (phase >= q3Ph);
    else         upDir = (phase >= halfPh);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      enQ     <= 1'b0;
      centerQ <= 1'b0;
      codeQ   <= '0;
      phase   <= '0;
      errQ    <= 1'b0;
    end else begin
      if (loadCfg) begin
        enQ     <= enReq;
        centerQ <= centerReq;
        codeQ   <= codeReq;
        phase   <= '0;
        if (enReq && codeReq[2]) errQ <= 1'b1;
      end else begin
        phase <= phase + PH_W'(1);
      end
    end
  end

  assign activeQ      = running;
  assign ctl.stepEn   = running;
  assign ctl.stepUp   = upDir;
  assign ctl.holdZero = !running;
  assign ctl.depthSel = codeQ[1:0];

endmodule

// File: rtl/ssc_datapath.sv
module ssc_datapath
  import ssc_pkg::*;
#(
  parameter int DIV_W      = 32,
  parameter int HALF_SLOW  = 396,
  parameter int HALF_FAST  = 794,
  parameter int DEN_NARROW = 400,
  parameter int DEN_WIDE   = 200,
  parameter int POS_W      = $clog2(HALF_FAST + 1) + 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  rampCtl_t                ctl,
  input  logic [DIV_W-1:0]        nomIn,
  output logic [DIV_W-1:0]        divOut,
  output logic signed [POS_W-1:0] posQ
);

  localparam int PROD_W = DIV_W + 1 + POS_W;

  logic signed [PROD_W-1:0] prod;
  logic signed [PROD_W-1:0] quot [4];
  logic signed [PROD_W-1:0] sum;

  always_ff @(posedge clk) begin
    if (rst || ctl.holdZero)  posQ <= '0;
    else if (ctl.stepEn)      posQ <= ctl.stepUp ? posQ + POS_W'(1) : posQ - POS_W'(1);
  end

  assign prod = signed'(PROD_W'({1'b0, nomIn})) * PROD_W'(posQ);

  // One constant-divisor quotient per length/depth combination
  for (genvar g = 0; g < 4; g++) begin : g_depth
    localparam int HALF_G = (g >= 2) ? HALF_FAST : HALF_SLOW;
    localparam int DEN_G  = (g % 2 == 1) ? DEN_WIDE : DEN_NARROW;
    localparam logic signed [PROD_W-1:0] DIVISOR = PROD_W'(HALF_G * DEN_G);
    assign quot[g] = prod / DIVISOR;
  end

  assign sum    = signed'(PROD_W'({1'b0, nomIn})) + quot[ctl.depthSel];
  assign divOut = sum[DIV_W-1:0];

endmodule

// File: rtl/ssc_modulator.sv
module ssc_modulator
  import ssc_pkg::*;
#(
  parameter int DIV_W      = 32,
  parameter int HALF_SLOW  = 396,
  parameter int HALF_FAST  = 794,
  parameter int DEN_NARROW = 400,
  parameter int DEN_WIDE   = 200
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sscEnable,
  input  logic             centerMode,
  input  logic [2:0]       depthCode,
  input  logic [DIV_W-1:0] nomDiv,
  output logic [DIV_W-1:0] modDiv,
  output logic             modActive,
  output logic             codeError
);

  localparam int POS_W = $clog2(HALF_FAST + 1) + 1;

  rampCtl_t                rampCtl;
  logic                    cfgCenter;
  logic [2:0]              cfgCode;
  logic signed [POS_W-1:0] rampPos;

  ssc_ctrl #(
    .HALF_SLOW(HALF_SLOW),
    .HALF_FAST(HALF_FAST)
  ) i_ctrl (
    .clk      (clk),
    .rst      (rst),
    .enReq    (sscEnable),
    .centerReq(centerMode),
    .codeReq  (depthCode),
    .ctl      (rampCtl),
    .centerQ  (cfgCenter),
    .codeQ    (cfgCode),
    .activeQ  (modActive),
    .errQ     (codeError)
  );

  ssc_datapath #(
    .DIV_W     (DIV_W),
    .HALF_SLOW (HALF_SLOW),
    .HALF_FAST (HALF_FAST),
    .DEN_NARROW(DEN_NARROW),
    .DEN_WIDE  (DEN_WIDE),
    .POS_W     (POS_W)
  ) i_datapath (
    .clk   (clk),
    .rst   (rst),
    .ctl   (rampCtl),
    .nomIn (nomDiv),
    .divOut(modDiv),
    .posQ  (rampPos)
  );

endmodule

// File: rtl/ssc_modulator_chk.sv
module ssc_modulator_chk #(
  parameter int DIV_W     = 32,
  parameter int HALF_FAST = 794,
  parameter int POS_W     = $clog2(HALF_FAST + 1) + 1
) (
  input logic                    clk,
  input logic                    rst,
  input logic [DIV_W-1:0]        nomDiv,
  input logic [DIV_W-1:0]        modDiv,
  input logic                    modActive,
  input logic                    codeError,
  input logic                    centerQ,
  input logic [2:0]              codeQ,
  input logic signed [POS_W-1:0] posQ
);

  localparam logic signed [POS_W-1:0] QMAX = POS_W'(HALF_FAST / 2);

  assert_idle_nominal_R2: assert property (@(posedge clk) disable iff (rst)
    !modActive |-> modDiv == nomDiv);

  assert_unit_step_R1: assert property (@(posedge clk) disable iff (rst)
    modActive |=> (POS_W'(posQ - $past(posQ)) == POS_W'(1)) ||
                  (POS_W'($past(posQ) - posQ) == POS_W'(1)));

  assert_down_below_R3: assert property (@(posedge clk) disable iff (rst)
    (modActive && !centerQ) |-> (modDiv <= nomDiv) && (posQ <= 0));

  assert_center_bound_R4: assert property (@(posedge clk) disable iff (rst)
    (modActive && centerQ) |-> (posQ <= QMAX) && (posQ >= -QMAX));

  assert_reserved_idle_R7: assert property (@(posedge clk) disable iff (rst)
    codeQ[2] |-> !modActive);

  assert_sticky_error_R7: assert property (@(posedge clk) disable iff (rst)
    codeError |=> codeError);

  assert_boundary_only_R8: assert property (@(posedge clk) disable iff (rst)
    !$stable({centerQ, codeQ, modActive}) |-> posQ == 0);

endmodule

bind ssc_modulator ssc_modulator_chk #(
  .DIV_W    (DIV_W),
  .HALF_FAST(HALF_FAST),
  .POS_W    (POS_W)
) i_chk (
  .clk      (clk),
  .rst      (rst),
  .nomDiv   (nomDiv),
  .modDiv   (modDiv),
  .modActive(modActive),
  .codeError(codeError),
  .centerQ  (cfgCenter),
  .codeQ    (cfgCode),
  .posQ     (rampPos)
);

// File: tb/test_ssc_modulator.sv
module test_ssc_modulator;

  localparam int DIV_W = 32;
  localparam int HS    = 396;
  localparam int HF    = 794;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             sscEnable = 1'b0;
  logic             centerMode = 1'b0;
  logic [2:0]       depthCode = '0;
  logic [DIV_W-1:0] nomDiv = 32'h0400_0000;
  logic [DIV_W-1:0] modDiv;
  logic             modActive;
  logic             codeError;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ssc_modulator i_ssc_modulator (
    .clk       (clk),
    .rst       (rst),
    .sscEnable (sscEnable),
    .centerMode(centerMode),
    .depthCode (depthCode),
    .nomDiv    (nomDiv),
    .modDiv    (modDiv),
    .modActive (modActive),
    .codeError (codeError)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int expPos(input bit center, input int h, input int t);
    if (!center) return (t <= h) ? -t : t - 2 * h;
    if (t <= h / 2) return t;
    if (t <= 3 * h / 2) return h - t;
    return t - 2 * h;
  endfunction

  // Drive a setting at a negedge, then check len cycles; optionally change
  // the inputs after cycle chgAt while still expecting the old setting.
  task automatic sweep(input bit en, input bit ctr, input logic [2:0] code,
                       input logic [31:0] nom, input int len, input string tagOvr,
                       input int chgAt, input bit cEn, input bit cCtr,
                       input logic [2:0] cCode);
    bit valid;
    int h, den, t, p;
    longint n, expv;
    string tag;
    sscEnable  = en;
    centerMode = ctr;
    depthCode  = code;
    nomDiv     = nom;
    valid = en && !code[2];
    h     = code[1] ? HF : HS;
    den   = code[0] ? 200 : 400;
    n     = longint'(nom);
    for (int j = 0; j < len; j++) begin
      @(posedge clk);
      @(negedge clk);
      t = j % (2 * h);
      p = valid ? expPos(ctr, h, t) : 0;
      expv = n + (n * p) / longint'(den * h);
      if (tagOvr != "") tag = tagOvr;
      else if (!valid) tag = "R2";
      else if (j == 1) tag = "R1";
      else if (t == 0 && j > 0) tag = "R5";
      else if ((!ctr && t == h) || (ctr && (t == h / 2 || t == 3 * h / 2))) tag = "R6";
      else tag = ctr ? "R4" : "R3";
      check(tag, longint'(modDiv), expv);
      check("R10", longint'(modActive), longint'(valid));
      if (j == chgAt) begin
        sscEnable  = cEn;
        centerMode = cCtr;
        depthCode  = cCode;
      end
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: reset state
    check("R9", longint'(modDiv), longint'(nomDiv));
    check("R9", longint'(modActive), 0);
    check("R9", longint'(codeError), 0);
    rst = 1'b0;

    // R2: disabled, every mode and code, reserved included
    for (int c = 0; c < 8; c++) begin
      for (int m = 0; m < 2; m++) begin
        sweep(1'b0, m[0], c[2:0], 32'h0400_0000, 2, "R2", -1, 0, 0, 0);
      end
    end
    check("R7", longint'(codeError), 0);

    // R3/R4/R5/R6: two full periods for each code, mode and nominal
    for (int k = 0; k < 2; k++) begin
      for (int c = 0; c < 4; c++) begin
        for (int m = 0; m < 2; m++) begin
          sweep(1'b1, m[0], c[2:0], (k == 0) ? 32'h0400_0000 : 32'h3A5B_1C07,
                2 * 2 * (c[1] ? HF : HS), "", -1, 0, 0, 0);
        end
      end
    end

    // R8: change mid-period; the old setting holds to the boundary
    sweep(1'b1, 1'b1, 3'd1, 32'h3A5B_1C07, 2 * HS, "R8", 100, 1'b1, 1'b0, 3'd3);
    sweep(1'b1, 1'b0, 3'd3, 32'h3A5B_1C07, 2 * HF, "R8", -1, 0, 0, 0);
    // R8: disable mid-period; modulation continues to the boundary
    sweep(1'b1, 1'b0, 3'd0, 32'h3A5B_1C07, 2 * HS, "R8", 50, 1'b0, 1'b0, 3'd0);
    sweep(1'b0, 1'b0, 3'd0, 32'h3A5B_1C07, 4, "R8", -1, 0, 0, 0);

    // R7: reserved code while enabled
    sweep(1'b1, 1'b1, 3'd6, 32'h3A5B_1C07, 20, "R7", -1, 0, 0, 0);
    check("R7", longint'(codeError), 1);
    sweep(1'b1, 1'b0, 3'd2, 32'h3A5B_1C07, 2 * HF, "", -1, 0, 0, 0);
    check("R7", longint'(codeError), 1);

    // R9: reset in the middle of a sweep
    sweep(1'b1, 1'b1, 3'd3, 32'h3A5B_1C07, 300, "", -1, 0, 0, 0);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R9", longint'(modDiv), longint'(nomDiv));
    check("R9", longint'(modActive), 0);
    check("R9", longint'(codeError), 0);
    rst = 1'b0;
    sweep(1'b1, 1'b1, 3'd3, 32'h3A5B_1C07, 2 * HF, "", -1, 0, 0, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule